// File: doc/BRIEF.md
# Multi-Mode LCD Timing Generator

This block produces the raster timing for a parallel RGB panel. It runs a horizontal pixel counter and a vertical line counter, and from them it derives an active-low horizontal sync, an active-low vertical sync and a data-enable strobe. Five fixed timing sets are built in. A 3-bit mode code from the configuration logic selects one of them. Two of the codes resolve to the same timing set. The two codes that name no timing set put the block into an error state, in which the outputs stay idle.

A mode code takes effect only at a frame boundary, so a frame is never cut short or stretched part-way through. A standby input blanks the panel outputs while the counters keep running. This keeps the frame phase intact for a later wake-up. The outputs are registered and change only on the rising edge of the pixel clock. The pixel clock rate for each mode and the formatting of pixel data are handled outside this block.

Top module: `lcd_tgen`

## Requirements
- R1: While reset is held, hcount and vcount read 0, de reads 0, hsync_n and vsync_n read 1, and mode_err reads 0 (the reset mode code is valid; by default it is 7).
- R2: In a valid mode, hcount advances by one on each clock from 0 to htotal-1 and then wraps to 0. vcount advances by one at each wrap of hcount, from 0 to vtotal-1, and then wraps to 0. htotal is the sum of the active width, front porch, sync width and back porch, and vtotal is the same sum for the vertical axis.
- R3: hsync_n is 0 exactly when hcount is at least active+front porch and below active+front porch+sync width. vsync_n follows the same rule applied to vcount.
- R4: de is 1 exactly when hcount is below the active width, vcount is below the active height, the mode is valid and standby was 0 at the last clock edge.
- R5: The code-to-timing map (active, front porch, sync, back porch) is: code 7 gives 800/40/1/216 by 480/10/1/35; code 6 gives 640/24/1/136 by 480/18/1/27; code 4 gives 480/2/1/43 by 640/4/1/8; codes 5 and 1 both give 480/2/1/43 by 272/2/1/12; code 0 gives 400/20/1/108 by 240/2/1/20.
- R6: If an unsupported code (2 or 3) is latched, then on the following cycles mode_err is 1, hcount and vcount stay at 0, de is 0 and both syncs are 1. In this state the mode code is sampled on every clock, so a valid code takes effect at the next edge and counting starts from 0.
- R7: In a valid mode, mode_code is sampled only on the edge where the counters wrap from (htotal-1, vtotal-1) to (0, 0). Changes at any other time do not affect the frame in progress.
- R8: standby is sampled on each clock. While it is 1, de is 0 and both syncs are 1 from the next cycle on, and the counters keep advancing as in R2.
- R9: All panel outputs are registered and match the hcount and vcount shown in the same cycle. In the first cycle after reset is released, the outputs are still idle (de 0, syncs 1).
- R10: With the default tables and code 7, the first line has de high for hcount 0 to 799 and hsync_n low only at hcount 840, and the line is 1057 clocks long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_code | input | 3 | Resolution code from the configuration logic |
| standby | input | 1 | When 1, blanks de and both syncs |
| hcount | output | 13 | Horizontal pixel position in the current line |
| vcount | output | 13 | Vertical line position in the current frame |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high over the active area |
| mode_err | output | 1 | High while the latched code is unsupported |

## Verification
On every cycle, the assertions check several properties: hcount only steps by one away from zero; the selected timing set never changes while the counters are away from the frame origin; a sync pulse never overlaps de; standby at an edge blanks de; and the error state holds the counters and outputs idle. Other behaviours need the bench's scenarios. These are the exact porch and sync positions of each timing set, the aliasing of code 1 onto code 5, recovery from an unsupported code, mode changes issued mid-frame, and the default-table line timing. The bench checks them by sweeping every code, including per-cycle code changes, over a scaled-down table, with a per-cycle arithmetic model.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;

    localparam int unsigned TW     = 11;
    localparam int unsigned CW     = TW + 2;
    localparam int unsigned NSLOT  = 5;
    localparam int unsigned SLOT_W = $clog2(NSLOT);
    localparam int unsigned CODE_W = 3;

    typedef logic [TW-1:0] tval_t;

    typedef struct packed {
        tval_t act;
        tval_t fp;
        tval_t sw;
        tval_t bp;
    } axis_tm_t;

    typedef struct packed {
        axis_tm_t h;
        axis_tm_t v;
    } mode_tm_t;

    typedef mode_tm_t [NSLOT-1:0] tm_tbl_t;

    typedef struct packed {
        logic              ok;
        logic [SLOT_W-1:0] slot;
    } msel_t;

    typedef struct packed {
        logic [CW-1:0] h;
        logic [CW-1:0] v;
    } cnt_t;

    typedef struct packed {
        logic hs_n;
        logic vs_n;
        logic de;
        logic err;
    } pout_t;

    function automatic mode_tm_t mk_mode(input int ha, input int hf, input int hs, input int hb,
                                         input int va, input int vf, input int vs, input int vb);
        mode_tm_t m;
        m.h.act = tval_t'(ha);
        m.h.fp  = tval_t'(hf);
        m.h.sw  = tval_t'(hs);
        m.h.bp  = tval_t'(hb);
        m.v.act = tval_t'(va);
        m.v.fp  = tval_t'(vf);
        m.v.sw  = tval_t'(vs);
        m.v.bp  = tval_t'(vb);
        return m;
    endfunction

    // slot 4: 800x480, 3: 640x480, 2: 480x640, 1: 480x272, 0: 400x240
    localparam tm_tbl_t DEFAULT_TBL = {
        mk_mode(800, 40, 1, 216, 480, 10, 1, 35),
        mk_mode(640, 24, 1, 136, 480, 18, 1, 27),
        mk_mode(480,  2, 1,  43, 640,  4, 1,  8),
        mk_mode(480,  2, 1,  43, 272,  2, 1, 12),
        mk_mode(400, 20, 1, 108, 240,  2, 1, 20)
    };

    function automatic msel_t decode_code(input logic [CODE_W-1:0] c);
        msel_t s;
        s.ok   = 1'b1;
        s.slot = '0;
        case (c)
            3'd0:       s.slot = SLOT_W'(0);
            3'd1, 3'd5: s.slot = SLOT_W'(1);
            3'd4:       s.slot = SLOT_W'(2);
            3'd6:       s.slot = SLOT_W'(3);
            3'd7:       s.slot = SLOT_W'(4);
            default:    s.ok   = 1'b0;
        endcase
        return s;
    endfunction

    function automatic logic [CW-1:0] widen(input tval_t v);
        return CW'(v);
    endfunction

    function automatic logic [CW-1:0] axis_total(input axis_tm_t a);
        return widen(a.act) + widen(a.fp) + widen(a.sw) + widen(a.bp);
    endfunction

    function automatic logic in_sync(input logic [CW-1:0] pos, input axis_tm_t a);
        logic [CW-1:0] lo;
        lo = widen(a.act) + widen(a.fp);
        return (pos >= lo) && (pos < lo + widen(a.sw));
    endfunction

endpackage

// File: rtl/lcd_tgen_mode.sv
module lcd_tgen_mode
    import lcd_tgen_pkg::*;
#(
    parameter tm_tbl_t           TBL        = DEFAULT_TBL,
    parameter logic [CODE_W-1:0] RESET_CODE = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] mode_code,
    input  logic              frame_end,
    output msel_t             sel_q,
    output msel_t             sel_d,
    output mode_tm_t          tm_q,
    output mode_tm_t          tm_d
);

    function automatic mode_tm_t pick(input msel_t s);
        mode_tm_t t;
        t = TBL[0];
        for (int i = 0; i < NSLOT; i++) begin
            if (s.slot == SLOT_W'(i)) t = TBL[i];
        end
        return t;
    endfunction

    always_comb begin
        sel_d = sel_q;
        // A valid mode reloads only at the frame wrap; an invalid one retries every clock.
        if (frame_end || !sel_q.ok) begin
            sel_d = decode_code(mode_code);
        end
    end

    assign tm_q = pick(sel_q);
    assign tm_d = pick(sel_d);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= decode_code(RESET_CODE);
        end else begin
            sel_q <= sel_d;
        end
    end

endmodule

// File: rtl/lcd_tgen_cnt.sv
module lcd_tgen_cnt
    import lcd_tgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  mode_tm_t tm,
    input  logic     run,
    output cnt_t     cnt_q,
    output cnt_t     cnt_d,
    output logic     frame_end
);

    logic [CW-1:0] h_last;
    logic [CW-1:0] v_last;
    logic          line_end;

    always_comb begin
        h_last    = axis_total(tm.h) - CW'(1);
        v_last    = axis_total(tm.v) - CW'(1);
        line_end  = run && (cnt_q.h == h_last);
        frame_end = line_end && (cnt_q.v == v_last);

        cnt_d = cnt_q;
        if (!run) begin
            cnt_d.h = '0;
            cnt_d.v = '0;
        end else if (line_end) begin
            cnt_d.h = '0;
            cnt_d.v = (cnt_q.v == v_last) ? '0 : cnt_q.v + CW'(1);
        end else begin
            cnt_d.h = cnt_q.h + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lcd_tgen_out.sv
module lcd_tgen_out
    import lcd_tgen_pkg::*;
#(
    parameter logic RESET_ERR = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cnt_t     cnt_d,
    input  mode_tm_t tm_d,
    input  logic     ok_d,
    input  logic     standby,
    output pout_t    pout_q
);

    pout_t pout_d;

    always_comb begin
        pout_d.err  = !ok_d;
        pout_d.hs_n = 1'b1;
        pout_d.vs_n = 1'b1;
        pout_d.de   = 1'b0;
        if (ok_d && !standby) begin
            pout_d.hs_n = !in_sync(cnt_d.h, tm_d.h);
            pout_d.vs_n = !in_sync(cnt_d.v, tm_d.v);
            pout_d.de   = (cnt_d.h < widen(tm_d.h.act)) && (cnt_d.v < widen(tm_d.v.act));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pout_q <= '{hs_n: 1'b1, vs_n: 1'b1, de: 1'b0, err: RESET_ERR};
        end else begin
            pout_q <= pout_d;
        end
    end

endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen
    import lcd_tgen_pkg::*;
#(
    parameter tm_tbl_t           TBL        = DEFAULT_TBL,
    parameter logic [CODE_W-1:0] RESET_CODE = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] mode_code,
    input  logic              standby,
    output logic [CW-1:0]     hcount,
    output logic [CW-1:0]     vcount,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              de,
    output logic              mode_err
);

    localparam msel_t RESET_SEL = decode_code(RESET_CODE);

    msel_t               sel_q;
    msel_t               sel_d;
    mode_tm_t            tm_q;
    mode_tm_t            tm_d;
    cnt_t                cnt_q;
    cnt_t                cnt_d;
    logic                frame_end;
    pout_t               pout_q;
    logic [SLOT_W-1:0]   cur_slot;

    lcd_tgen_mode #(
        .TBL        (TBL),
        .RESET_CODE (RESET_CODE)
    ) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_code (mode_code),
        .frame_end (frame_end),
        .sel_q     (sel_q),
        .sel_d     (sel_d),
        .tm_q      (tm_q),
        .tm_d      (tm_d)
    );

    lcd_tgen_cnt u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tm        (tm_q),
        .run       (sel_q.ok),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d),
        .frame_end (frame_end)
    );

    lcd_tgen_out #(
        .RESET_ERR (!RESET_SEL.ok)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_d   (cnt_d),
        .tm_d    (tm_d),
        .ok_d    (sel_d.ok),
        .standby (standby),
        .pout_q  (pout_q)
    );

    assign cur_slot = sel_q.slot;
    assign hcount   = cnt_q.h;
    assign vcount   = cnt_q.v;
    assign hsync_n  = pout_q.hs_n;
    assign vsync_n  = pout_q.vs_n;
    assign de       = pout_q.de;
    assign mode_err = pout_q.err;

endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk
    import lcd_tgen_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              standby,
    input logic [CW-1:0]     hcount,
    input logic [CW-1:0]     vcount,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic              de,
    input logic              mode_err,
    input logic [SLOT_W-1:0] slot
);

    // R2
    hcount_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount != '0) |-> (hcount == $past(hcount) + CW'(1)));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hcount != '0) || (vcount != '0)) |-> $stable(slot));

    // R3
    sync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync_n || !vsync_n) |-> !de);

    // R8
    standby_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(standby) |-> !de);

    // R6
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (!de && hsync_n && vsync_n && hcount == '0 && vcount == '0));

endmodule

bind lcd_tgen lcd_tgen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby  (standby),
    .hcount   (hcount),
    .vcount   (vcount),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n),
    .de       (de),
    .mode_err (mode_err),
    .slot     (cur_slot)
);

// File: tb/tb_lcd_tgen.sv
`timescale 1ns/1ps
module tb_lcd_tgen;
    import lcd_tgen_pkg::*;

    // Scaled-down timing sets, slot order 0..4
    localparam int HA [5] = '{4, 5, 3, 6, 7};
    localparam int HF [5] = '{1, 2, 1, 1, 2};
    localparam int HS [5] = '{1, 1, 2, 1, 1};
    localparam int HB [5] = '{2, 1, 2, 1, 2};
    localparam int VA [5] = '{3, 2, 4, 3, 4};
    localparam int VF [5] = '{1, 1, 2, 1, 1};
    localparam int VS [5] = '{1, 2, 1, 1, 1};
    localparam int VB [5] = '{1, 1, 1, 2, 1};

    localparam tm_tbl_t SMALL = {
        mk_mode(7, 2, 1, 2, 4, 1, 1, 1),
        mk_mode(6, 1, 1, 1, 3, 1, 1, 2),
        mk_mode(3, 1, 2, 2, 4, 2, 1, 1),
        mk_mode(5, 2, 1, 1, 2, 1, 2, 1),
        mk_mode(4, 1, 1, 2, 3, 1, 1, 1)
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode_code = 3'd7;
    logic          standby = 1'b0;
    logic [CW-1:0] hcount, vcount, d_hcount, d_vcount;
    logic          hsync_n, vsync_n, de, mode_err;
    logic          d_hsync_n, d_vsync_n, d_de, d_mode_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit def_done = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lcd_tgen #(.TBL(SMALL), .RESET_CODE(3'd7)) dut (
        .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .standby(standby),
        .hcount(hcount), .vcount(vcount), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .de(de), .mode_err(mode_err)
    );

    lcd_tgen dut_def (
        .clk(clk), .rst_n(rst_n), .mode_code(3'd7), .standby(1'b0),
        .hcount(d_hcount), .vcount(d_vcount), .hsync_n(d_hsync_n), .vsync_n(d_vsync_n),
        .de(d_de), .mode_err(d_mode_err)
    );

    // model state
    int mh, mv, mslot;
    bit mok;
    bit e_hs, e_vs, e_de, e_err;

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit tb_dec(input int c, output int s);
        s = 0;
        case (c)
            0: s = 0;
            1: s = 1;
            5: s = 1;
            4: s = 2;
            6: s = 3;
            7: s = 4;
            default: return 1'b0;
        endcase
        return 1'b1;
    endfunction

    task automatic check_all(input string tag);
        chk(hcount == CW'(mh), tag, "hcount", int'(hcount), mh);
        chk(vcount == CW'(mv), tag, "vcount", int'(vcount), mv);
        chk(hsync_n == e_hs, "R3", "hsync_n", int'(hsync_n), int'(e_hs));
        chk(vsync_n == e_vs, "R3", "vsync_n", int'(vsync_n), int'(e_vs));
        chk(de == e_de, "R4", "de", int'(de), int'(e_de));
        chk(mode_err == e_err, "R6", "mode_err", int'(mode_err), int'(e_err));
    endtask

    task automatic model_step(input int code, input bit sb);
        bit load;
        int ht, vt, s;
        load = 1'b0;
        if (!mok) begin
            mh = 0; mv = 0; load = 1'b1;
        end else begin
            ht = HA[mslot] + HF[mslot] + HS[mslot] + HB[mslot];
            vt = VA[mslot] + VF[mslot] + VS[mslot] + VB[mslot];
            if (mh == ht - 1) begin
                mh = 0;
                if (mv == vt - 1) begin
                    mv = 0; load = 1'b1;
                end else begin
                    mv++;
                end
            end else begin
                mh++;
            end
        end
        if (load) begin
            mok = tb_dec(code, s);
            mslot = s;
        end
        e_err = !mok;
        e_hs = 1'b1; e_vs = 1'b1; e_de = 1'b0;
        if (mok && !sb) begin
            e_de = (mh < HA[mslot]) && (mv < VA[mslot]);
            e_hs = !((mh >= HA[mslot] + HF[mslot]) && (mh < HA[mslot] + HF[mslot] + HS[mslot]));
            e_vs = !((mv >= VA[mslot] + VF[mslot]) && (mv < VA[mslot] + VF[mslot] + VS[mslot]));
        end
    endtask

    task automatic tick(input int code, input bit sb, input string tag);
        check_all(tag);
        mode_code = 3'(code);
        standby = sb;
        model_step(code, sb);
        @(negedge clk);
    endtask

    task automatic run(input int n, input int code, input bit sb, input string tag);
        for (int i = 0; i < n; i++) tick(code, sb, tag);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // R10: default table, code 7, first line
    initial begin
        @(posedge rst_n);
        for (int k = 1; k <= 1057; k++) begin
            @(negedge clk);
            if (k == 799)  chk(d_de == 1'b1, "R10", "de at 799", int'(d_de), 1);
            if (k == 800)  chk(d_de == 1'b0, "R10", "de at 800", int'(d_de), 0);
            if (k == 839)  chk(d_hsync_n == 1'b1, "R10", "hsync_n at 839", int'(d_hsync_n), 1);
            if (k == 840)  chk(d_hsync_n == 1'b0, "R10", "hsync_n at 840", int'(d_hsync_n), 0);
            if (k == 841)  chk(d_hsync_n == 1'b1, "R10", "hsync_n at 841", int'(d_hsync_n), 1);
            if (k == 1056) chk(d_hcount == CW'(1056), "R10", "hcount at end", int'(d_hcount), 1056);
            if (k == 1057) begin
                chk(d_hcount == '0, "R10", "hcount wrap", int'(d_hcount), 0);
                chk(d_vcount == CW'(1), "R10", "vcount step", int'(d_vcount), 1);
                chk(d_vsync_n == 1'b1, "R10", "vsync_n line 1", int'(d_vsync_n), 1);
            end
        end
        def_done = 1'b1;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(hcount == '0, "R1", "hcount", int'(hcount), 0);
        chk(vcount == '0, "R1", "vcount", int'(vcount), 0);
        chk(de == 1'b0, "R1", "de", int'(de), 0);
        chk(hsync_n && vsync_n, "R1", "syncs", int'({hsync_n, vsync_n}), 3);
        chk(mode_err == 1'b0, "R1", "mode_err", int'(mode_err), 0);
        rst_n = 1'b1;
        mh = 0; mv = 0; mok = 1'b1; mslot = 4;
        e_hs = 1'b1; e_vs = 1'b1; e_de = 1'b0; e_err = 1'b0;
        tick(7, 1'b0, "R9");
        run(170, 7, 1'b0, "R2");
        run(30, 7, 1'b0, "R2");
        // R7: request a new mode mid-frame; old frame must finish
        run(120, 6, 1'b0, "R7");
        // R5: every supported code, including the alias
        run(160, 5, 1'b0, "R5");
        run(160, 1, 1'b0, "R5");
        run(160, 4, 1'b0, "R5");
        run(160, 0, 1'b0, "R5");
        // R6: unsupported codes then recovery
        run(130, 2, 1'b0, "R6");
        run(10, 3, 1'b0, "R6");
        run(100, 7, 1'b0, "R6");
        // R8: standby mid-frame, then release
        run(50, 7, 1'b1, "R8");
        run(60, 7, 1'b0, "R8");
        run(20, 6, 1'b1, "R8");
        // R7: code changes on every cycle
        for (int i = 0; i < 600; i++) tick((i * 5 + i / 7) % 8, (i % 23) < 4, "R7");
        check_all("R7");
        wait (def_done);
        finish_up();
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule